// File: doc/BRIEF.md
# Three-Axis Sensor Register Bank

This block holds the byte-addressed register file of a three-axis field sensor. The host sees it through one byte-wide port. The port has an address load strobe, a read strobe, a write strobe, a write data byte and a read data byte.

A loaded address sets an internal pointer. Every read strobe returns the byte at the pointer and then moves the pointer on, so a host can stream the status byte and all axis samples in one burst. In fast mode the bursts visit only the axis high bytes, which halves the traffic when 8-bit resolution is enough. Samples, status, operating mode and die temperature arrive from the neighbouring acquisition logic as plain inputs.

The control bytes and the three 15-bit axis offsets are held here and driven out to that logic. Several fields read back with fixed zero bits.

Top module: `sensor_regbank`

## Requirements
- R1: Reading address 0x00 returns the status input. Addresses 0x01/0x02, 0x03/0x04 and 0x05/0x06 hold the X, Y and Z samples, with bits 15..8 at the odd address and bits 7..0 at the even address. Address 0x0F returns the temperature input, 0x10 returns control byte 1 and 0x11 returns control byte 2. Any address from 0x12 upward reads 0x00.
- R2: Address 0x07 always reads 0xC4.
- R3: In normal mode (control 1 bit 2 clear), each read strobe advances the pointer by one, except that a read at 0x06 returns the pointer to 0x00.
- R4: In fast mode (control 1 bit 2 set), a read at 0x01 moves the pointer to 0x03, a read at 0x03 moves it to 0x05, and a read at 0x05 moves it to 0x00. A read at any other address advances the pointer by one.
- R5: Reading an axis high byte captures that axis's low byte. A later read of the low-byte address returns the captured byte, even if a new sample has been loaded in between.
- R6: Address 0x08 returns the 2-bit mode input in bits 1..0; bits 7..2 read 0.
- R7: Offsets sit at 0x09/0x0A (X), 0x0B/0x0C (Y) and 0x0D/0x0E (Z). The odd address holds offset bits 14..7. The even address holds offset bits 6..0 in register bits 7..1, and its bit 0 reads 0. The stored 15-bit offsets appear on offX, offY and offZ.
- R8: Control byte 2 keeps only bits 4, 5 and 7; bits 0..3 and 6 read 0. Bit 4 is a one-shot and clears one cycle after the write that sets it.
- R9: Writes to addresses 0x00..0x08 and 0x0F change nothing readable.
- R10: An address load sets the pointer. A write stores at the pointer and leaves the pointer where it is.
- R11: After reset, the pointer, the control bytes, the offsets, the samples and the captured low bytes are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrLoad | input | 1 | Load addrIn into the pointer |
| addrIn | input | 8 | Register address to load |
| rdStb | input | 1 | Read strobe; consumes rdData and advances the pointer |
| wrStb | input | 1 | Write strobe; stores wrData at the pointer |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Byte at the current pointer |
| sampleLoad | input | 1 | Capture sampleX/Y/Z into the axis registers |
| sampleX | input | 16 | X sample, two's complement |
| sampleY | input | 16 | Y sample, two's complement |
| sampleZ | input | 16 | Z sample, two's complement |
| statusIn | input | 8 | Status byte from the acquisition logic |
| modeIn | input | 2 | Current operating mode |
| tempIn | input | 8 | Die temperature byte |
| ctrl1Out | output | 8 | Control byte 1 |
| ctrl2Out | output | 8 | Control byte 2 (masked) |
| offX | output | 15 | X offset |
| offY | output | 15 | Y offset |
| offZ | output | 15 | Z offset |

## Verification
The bench targets the pointer's turning points: the wrap after 0x06, the fast-mode hops 0x01 to 0x03 to 0x05 to 0x00, and the plain step past 0x0F into the control bytes. A pointer rule that is off by one shows up as a shifted byte stream. The low-byte capture is tested by loading a new sample between the high and low reads; a design that reads the live register returns the torn value. Masked bits, the self-clearing reset bit and writes to read-only addresses are each checked by reading back, so a lost mask or a stray write enable shows as a wrong byte.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  localparam int BANK_PTR_W = 8;
  localparam int BYTE_W     = 8;
  localparam int NUM_AXES   = 3;
  localparam int AXIS_W     = 2 * BYTE_W;
  localparam int OFF_W      = AXIS_W - 1;

  localparam int ADR_STATUS = 0;
  localparam int ADR_AXIS0  = 1;
  localparam int ADR_LASTO  = ADR_AXIS0 + 2 * NUM_AXES - 1;
  localparam int ADR_IDENT  = ADR_LASTO + 1;
  localparam int ADR_MODE   = ADR_IDENT + 1;
  localparam int ADR_OFF0   = ADR_MODE + 1;
  localparam int ADR_TEMP   = ADR_OFF0 + 2 * NUM_AXES;
  localparam int ADR_CTL1   = ADR_TEMP + 1;
  localparam int ADR_CTL2   = ADR_CTL1 + 1;

  localparam logic [BYTE_W-1:0] IDENT_VALUE = 8'hC4;
  localparam logic [BYTE_W-1:0] CTL2_KEEP   = 8'hB0;
  localparam int                CTL2_PULSE  = 4;
  localparam int                CTL1_FAST   = 2;

  typedef struct packed {
    logic                  rdEn;
    logic                  wrEn;
    logic [BANK_PTR_W-1:0] addr;
  } bankStrobes_t;
endpackage

// File: rtl/regbank_ctrl.sv
`timescale 1ns/1ps
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  addrLoad,
  input  logic [BANK_PTR_W-1:0] addrIn,
  input  logic                  rdStb,
  input  logic                  wrStb,
  input  logic                  fastMode,
  output bankStrobes_t          strobes
);
  localparam logic [BANK_PTR_W-1:0] LAST_OUT  = BANK_PTR_W'(ADR_LASTO);
  localparam logic [BANK_PTR_W-1:0] LAST_HIGH = BANK_PTR_W'(ADR_LASTO - 1);

  logic [BANK_PTR_W-1:0] ptrQ;
  logic [BANK_PTR_W-1:0] ptrStep;
  logic                  isHighOut;

  always_comb begin
    isHighOut = (ptrQ >= BANK_PTR_W'(ADR_AXIS0)) && (ptrQ < LAST_HIGH) && ptrQ[0];
    if (!fastMode && ptrQ == LAST_OUT)
      ptrStep = '0;
    else if (fastMode && ptrQ == LAST_HIGH)
      ptrStep = '0;
    else if (fastMode && isHighOut)
      ptrStep = ptrQ + BANK_PTR_W'(2);
    else
      ptrStep = ptrQ + BANK_PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ptrQ <= '0;
    else if (addrLoad)
      ptrQ <= addrIn;
    else if (rdStb)
      ptrQ <= ptrStep;
  end

  always_comb begin
    strobes.addr = ptrQ;
    strobes.rdEn = rdStb && !addrLoad;
    strobes.wrEn = wrStb && !addrLoad;
  end

  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && !fastMode && ptrQ == LAST_OUT) |=> (ptrQ == '0)); // R3
  AST_FAST_HOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && fastMode && ptrQ == BANK_PTR_W'(ADR_AXIS0)) |=> (ptrQ == BANK_PTR_W'(ADR_AXIS0 + 2))); // R4
  AST_WRITE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !rdStb) |=> $stable(ptrQ)); // R10
endmodule

// File: rtl/regbank_dp.sv
`timescale 1ns/1ps
module regbank_dp
  import regbank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  bankStrobes_t                 strobes,
  input  logic [BYTE_W-1:0]            wrData,
  input  logic                         sampleLoad,
  input  logic [NUM_AXES*AXIS_W-1:0]   samplesIn,
  input  logic [BYTE_W-1:0]            statusIn,
  input  logic [1:0]                   modeIn,
  input  logic [BYTE_W-1:0]            tempIn,
  output logic [BYTE_W-1:0]            rdData,
  output logic [BYTE_W-1:0]            ctrl1Q,
  output logic [BYTE_W-1:0]            ctrl2Q,
  output logic [NUM_AXES*OFF_W-1:0]    offsetsOut
);
  localparam int LOW_OFF_W = OFF_W - BYTE_W;

  logic [AXIS_W-1:0] axisQ   [NUM_AXES];
  logic [BYTE_W-1:0] shadowQ [NUM_AXES];
  logic [OFF_W-1:0]  offQ    [NUM_AXES];

  function automatic logic hit(input logic [BANK_PTR_W-1:0] a, input int k);
    return a == BANK_PTR_W'(k);
  endfunction

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
    localparam int HI_ADR  = ADR_AXIS0 + 2 * i;
    localparam int OFF_ADR = ADR_OFF0 + 2 * i;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        axisQ[i]   <= '0;
        shadowQ[i] <= '0;
        offQ[i]    <= '0;
      end else begin
        if (sampleLoad)
          axisQ[i] <= samplesIn[i*AXIS_W +: AXIS_W];
        if (strobes.rdEn && hit(strobes.addr, HI_ADR))
          shadowQ[i] <= axisQ[i][BYTE_W-1:0];
        if (strobes.wrEn && hit(strobes.addr, OFF_ADR))
          offQ[i][OFF_W-1:LOW_OFF_W] <= wrData;
        if (strobes.wrEn && hit(strobes.addr, OFF_ADR + 1))
          offQ[i][LOW_OFF_W-1:0] <= wrData[BYTE_W-1:1];
      end
    end

    assign offsetsOut[i*OFF_W +: OFF_W] = offQ[i];

    AST_LOW_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.rdEn && hit(strobes.addr, HI_ADR)) |=> (shadowQ[i] == $past(axisQ[i][BYTE_W-1:0]))); // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl1Q <= '0;
      ctrl2Q <= '0;
    end else begin
      if (strobes.wrEn && hit(strobes.addr, ADR_CTL1))
        ctrl1Q <= wrData;
      if (strobes.wrEn && hit(strobes.addr, ADR_CTL2))
        ctrl2Q <= wrData & CTL2_KEEP;
      else
        ctrl2Q[CTL2_PULSE] <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (hit(strobes.addr, ADR_STATUS)) rdData = statusIn;
    if (hit(strobes.addr, ADR_IDENT))  rdData = IDENT_VALUE;
    if (hit(strobes.addr, ADR_MODE))   rdData = {{(BYTE_W-2){1'b0}}, modeIn};
    if (hit(strobes.addr, ADR_TEMP))   rdData = tempIn;
    if (hit(strobes.addr, ADR_CTL1))   rdData = ctrl1Q;
    if (hit(strobes.addr, ADR_CTL2))   rdData = ctrl2Q;
    for (int i = 0; i < NUM_AXES; i++) begin
      if (hit(strobes.addr, ADR_AXIS0 + 2 * i))     rdData = axisQ[i][AXIS_W-1:BYTE_W];
      if (hit(strobes.addr, ADR_AXIS0 + 2 * i + 1)) rdData = shadowQ[i];
      if (hit(strobes.addr, ADR_OFF0 + 2 * i))      rdData = offQ[i][OFF_W-1:LOW_OFF_W];
      if (hit(strobes.addr, ADR_OFF0 + 2 * i + 1))  rdData = {offQ[i][LOW_OFF_W-1:0], 1'b0};
    end
  end

  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    hit(strobes.addr, ADR_IDENT) |-> (rdData == IDENT_VALUE)); // R2
  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hit(strobes.addr, ADR_MODE) |-> (rdData[BYTE_W-1:2] == '0)); // R6
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl2Q[CTL2_PULSE] && !(strobes.wrEn && hit(strobes.addr, ADR_CTL2))) |=> !ctrl2Q[CTL2_PULSE]); // R8
  AST_CTL1_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrEn && hit(strobes.addr, ADR_CTL1)) |=> $stable(ctrl1Q)); // R9
endmodule

// File: rtl/sensor_regbank.sv
`timescale 1ns/1ps
module sensor_regbank
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [7:0]        addrIn,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              sampleLoad,
  input  logic [15:0]       sampleX,
  input  logic [15:0]       sampleY,
  input  logic [15:0]       sampleZ,
  input  logic [7:0]        statusIn,
  input  logic [1:0]        modeIn,
  input  logic [7:0]        tempIn,
  output logic [7:0]        ctrl1Out,
  output logic [7:0]        ctrl2Out,
  output logic [14:0]       offX,
  output logic [14:0]       offY,
  output logic [14:0]       offZ
);
  bankStrobes_t                  strobes;
  logic [NUM_AXES*OFF_W-1:0]     offsets;

  regbank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrLoad (addrLoad),
    .addrIn   (addrIn),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .fastMode (ctrl1Out[CTL1_FAST]),
    .strobes  (strobes)
  );

  regbank_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .sampleLoad (sampleLoad),
    .samplesIn  ({sampleZ, sampleY, sampleX}),
    .statusIn   (statusIn),
    .modeIn     (modeIn),
    .tempIn     (tempIn),
    .rdData     (rdData),
    .ctrl1Q     (ctrl1Out),
    .ctrl2Q     (ctrl2Out),
    .offsetsOut (offsets)
  );

  assign offX = offsets[0*OFF_W +: OFF_W];
  assign offY = offsets[1*OFF_W +: OFF_W];
  assign offZ = offsets[2*OFF_W +: OFF_W];
endmodule

// File: tb/tb_sensor_regbank.sv
`timescale 1ns/1ps
module tb_sensor_regbank;
  logic        clk = 0;
  logic        rstN = 0;
  logic        addrLoad = 0, rdStb = 0, wrStb = 0, sampleLoad = 0;
  logic [7:0]  addrIn = 0, wrData = 0, statusIn = 8'h5A, tempIn = 8'hE7;
  logic [1:0]  modeIn = 2'd2;
  logic [15:0] sampleX = 0, sampleY = 0, sampleZ = 0;
  logic [7:0]  rdData, ctrl1Out, ctrl2Out;
  logic [14:0] offX, offY, offZ;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  sensor_regbank dut (.*);

  always #10 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadAddr(input logic [7:0] a);
    @(negedge clk); addrLoad = 1; addrIn = a;
    @(negedge clk); addrLoad = 0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrStb = 1; wrData = d;
    @(negedge clk); wrStb = 0;
  endtask

  task automatic readExp(input logic [7:0] e, input string tag);
    @(negedge clk); rdStb = 1; expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); rdStb = 0;
  endtask

  task automatic loadSample(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    @(negedge clk); sampleX = x; sampleY = y; sampleZ = z; sampleLoad = 1;
    @(negedge clk); sampleLoad = 0;
  endtask

  // monitor: compares every consumed read byte against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rdStb) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL unexpected read actual=%h expected=none", rdData);
        end else begin
          check(rdData, expQ.pop_front(), tagQ.pop_front());
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(ctrl1Out, 8'h00, "R11 ctrl1");
    check(ctrl2Out, 8'h00, "R11 ctrl2");
    check(offX, 15'h0, "R11 offX");
    readExp(8'h5A, "R11 pointer at status");
    readExp(8'h00, "R11 X high zero");

    loadSample(16'h1234, 16'hABCD, 16'h8001);
    loadAddr(8'h00);
    readExp(8'h5A, "R1 status");
    readExp(8'h12, "R1 X high");
    readExp(8'h34, "R5 X low");
    readExp(8'hAB, "R1 Y high");
    readExp(8'hCD, "R5 Y low");
    readExp(8'h80, "R1 Z high");
    readExp(8'h01, "R3 Z low");
    readExp(8'h5A, "R3 wrap to status");

    loadAddr(8'h07);
    readExp(8'hC4, "R2 ident");
    readExp(8'h02, "R6 mode");

    // offsets
    loadAddr(8'h09); writeByte(8'hA5);
    loadAddr(8'h0A); writeByte(8'hFF);
    check(offX, 15'h52FF, "R7 offX");
    loadAddr(8'h0D); writeByte(8'h01);
    check(offZ, 15'h0080, "R7 offZ");
    loadAddr(8'h09);
    readExp(8'hA5, "R7 off high");
    readExp(8'hFE, "R7 off low bit0");

    // control 2 masking and one-shot
    loadAddr(8'h11);
    @(negedge clk); wrStb = 1; wrData = 8'hFF;
    @(negedge clk); wrStb = 0;
    check(ctrl2Out, 8'hB0, "R8 ctrl2 masked");
    @(negedge clk);
    check(ctrl2Out, 8'hA0, "R8 one-shot cleared");
    readExp(8'hA0, "R8 ctrl2 read");

    // read-only addresses ignore writes
    loadAddr(8'h07); writeByte(8'h00);
    loadAddr(8'h01); writeByte(8'h00);
    loadAddr(8'h08); writeByte(8'hFF);
    loadAddr(8'h0F); writeByte(8'h00);
    loadAddr(8'h00); writeByte(8'h00);
    check(ctrl1Out, 8'h00, "R9 ctrl1 untouched");
    loadAddr(8'h07);
    readExp(8'hC4, "R9 ident kept");
    readExp(8'h02, "R9 mode kept");
    loadAddr(8'h01);
    readExp(8'h12, "R9 X high kept");
    loadAddr(8'h0F);
    readExp(8'hE7, "R9 temp kept");
    readExp(8'h00, "R3 step into ctrl1");

    // write leaves pointer, fast mode on
    loadAddr(8'h10); writeByte(8'h04);
    readExp(8'h04, "R10 pointer held");
    readExp(8'hA0, "R1 ctrl2");
    readExp(8'h00, "R1 above map");

    loadAddr(8'h00);
    readExp(8'h5A, "R4 fast status");
    readExp(8'h12, "R4 fast X");
    readExp(8'hAB, "R4 fast Y");
    readExp(8'h80, "R4 fast Z");
    readExp(8'h5A, "R4 fast wrap");

    // capture across a new sample
    loadAddr(8'h10); writeByte(8'h00);
    loadAddr(8'h01);
    readExp(8'h12, "R5 old X high");
    loadSample(16'h5678, 16'hABCD, 16'h8001);
    readExp(8'h34, "R5 low captured");
    loadAddr(8'h01);
    readExp(8'h56, "R5 new X high");
    readExp(8'h78, "R5 new X low");

    repeat (4) @(negedge clk);
    check(expQ.size(), 0, "scoreboard drained");
    finish();
  end
endmodule